// File: doc/BRIEF.md
# IrDA SIR Pulse Modulator

This block sits between the serial output of a UART transmitter and an infrared LED driver. It reshapes the serial stream for low-speed infrared links at rates up to 115.2 kbps. Software sets a modulation enable and a low-power select through one 32-bit control word. With modulation off, the UART stream reaches the LED output unchanged as plain NRZ. With modulation on, each zero bit becomes one short high pulse and each one bit leaves the output low.

The pulse width comes from one of two timers. In normal mode it is 3 periods of the 16x baud tick, which is 3/16 of a bit cell. In low-power mode it is a fixed count of system clocks, `ceil(CLK_HZ * 1.6 us)`, and the baud rate has no effect on it. A bit-start strobe from the UART marks each bit boundary. A pulse can only begin at that strobe, when the strobe coincides with a baud tick.

Top module: `irsir_mod`

## Requirements
- R1: After reset the control word reads 0, and `ir_out` follows `txd` as in R3.
- R2: A write with `reg_we` high stores `reg_wdata[0]` as modulation enable and `reg_wdata[1]` as low-power select. From the next cycle `reg_rdata` returns `{30'b0, lowpower, enable}`, and bits 31:2 of the write have no effect.
- R3: While modulation enable is 0, `ir_out` equals the value `txd` had one clock earlier, with no pulse shaping.
- R4: With enable 1 and low-power 0, a zero bit produces one high pulse. The pulse starts the clock after the bit-start tick and lasts exactly `PULSE_TICKS` (default 3) baud-tick periods.
- R5: With enable 1, a one bit produces no pulse, and `ir_out` stays low for the whole bit. An all-ones byte therefore gives exactly one pulse per frame, for the start bit.
- R6: With enable 1 and low-power 1, a zero bit produces one high pulse of exactly `ceil(CLK_HZ*1.6us)` clocks (400 at 250 MHz), whatever the baud-tick spacing.
- R7: A pulse starts only when `bit_start`, `baud_tick` and a low `txd` are all present in the same cycle. A strobe without a tick, or a strobe during a running pulse, neither starts a pulse nor extends or restarts the running one.
- R8: Clearing the enable ends a running pulse at once. From the next cycle `ir_out` returns to NRZ following `txd`.
- R9: Changing the low-power select while a pulse runs does not change that pulse's width. The width is fixed by the mode in force when the pulse started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| bit_start | input | 1 | UART strobe marking the first tick of each bit cell |
| txd | input | 1 | UART serial data, idle high |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word (bit 0 enable, bit 1 low-power) |
| reg_rdata | output | 32 | Read-back of the control word |
| ir_out | output | 1 | Drive to the infrared LED, active high |

## Verification
The bench counts the pulses in each frame and measures the width of each pulse, in NRZ mode, 3/16 mode and fixed-width mode, using all-zero bytes, all-one bytes and random bytes. The checks catch three kinds of error:
- A timer that is off by one tick or one clock shows up as a width error.
- A design that pulses on one bits or drops a zero shows up as a count error.
- A design that retriggers on a stray strobe, or on a strobe during a pulse, shows up as an extra or stretched pulse.

Directed sequences clear the enable in mid-pulse, where a wrong design would leave the LED lit. They also flip the low-power select in mid-pulse, where a wrong design would cut the pulse short or stretch it.

// File: rtl/irsir_pkg.sv
`timescale 1ns/1ps
package irsir_pkg;

    // control word fields
    typedef struct packed {
        logic lp;   // fixed-width pulse select
        logic en;   // modulation enable
    } irsir_cfg_t;

    // top-level registered state
    typedef struct packed {
        logic txd;  // delayed UART data for the NRZ path
    } irsir_top_t;

endpackage

// File: rtl/irsir_cfg.sv
`timescale 1ns/1ps
module irsir_cfg
    import irsir_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             en,
    output logic             lp
);
    localparam int PAD_W = REG_W - 2;

    irsir_cfg_t cfg_d, cfg_q;

    logic unused_hi;
    assign unused_hi = ^wdata[REG_W-1:2];

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.en = wdata[0];
            cfg_d.lp = wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en    = cfg_q.en;
    assign lp    = cfg_q.lp;
    assign rdata = {{PAD_W{1'b0}}, cfg_q.lp, cfg_q.en};
endmodule

// File: rtl/irsir_tick_win.sv
`timescale 1ns/1ps
module irsir_tick_win #(
    parameter int PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic tick,
    output logic active
);
    localparam int CW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;    // tick periods still to run after the current one
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (clr) begin
            win_d = '0;
        end else if (start) begin
            win_d.active = 1'b1;
            win_d.cnt    = CW'(PULSE_TICKS - 1);
        end else if (win_q.active && tick) begin
            if (win_q.cnt == '0) win_d.active = 1'b0;
            else                 win_d.cnt    = win_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign active = win_q.active;
endmodule

// File: rtl/irsir_cyc_win.sv
`timescale 1ns/1ps
module irsir_cyc_win #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic active
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;    // clocks still to run after the current one
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (clr) begin
            win_d = '0;
        end else if (start) begin
            win_d.active = 1'b1;
            win_d.cnt    = CW'(CYCLES - 1);
        end else if (win_q.active) begin
            if (win_q.cnt == '0) win_d.active = 1'b0;
            else                 win_d.cnt    = win_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign active = win_q.active;
endmodule

// File: rtl/irsir_mod.sv
`timescale 1ns/1ps
module irsir_mod
    import irsir_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 250_000_000,
    parameter int          PULSE_TICKS = 3,
    parameter int          REG_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             bit_start,
    input  logic             txd,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             ir_out
);
    // fixed low-power pulse: ceil(CLK_HZ * 1.6e-6) clocks
    localparam int LP_CYCLES =
        int'((64'(CLK_HZ) * 64'd16 + 64'd9_999_999) / 64'd10_000_000);

    logic cfg_en, cfg_lp;
    logic tick_act, cyc_act;
    logic fire, busy;

    irsir_top_t top_d, top_q;

    irsir_cfg #(.REG_W(REG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .en    (cfg_en),
        .lp    (cfg_lp)
    );

    // start of a pulse: zero bit, at its first tick, when no pulse is running
    assign busy = tick_act | cyc_act;
    assign fire = cfg_en & bit_start & baud_tick & ~txd & ~busy;

    irsir_tick_win #(.PULSE_TICKS(PULSE_TICKS)) u_tick_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (~cfg_en),
        .start  (fire & ~cfg_lp),
        .tick   (baud_tick),
        .active (tick_act)
    );

    irsir_cyc_win #(.CYCLES(LP_CYCLES)) u_cyc_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (~cfg_en),
        .start  (fire & cfg_lp),
        .active (cyc_act)
    );

    always_comb begin
        top_d     = top_q;
        top_d.txd = txd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{txd: 1'b1};
        else        top_q <= top_d;
    end

    assign ir_out = cfg_en ? busy : top_q.txd;
endmodule

// File: rtl/irsir_mod_chk.sv
`timescale 1ns/1ps
module irsir_mod_chk #(
    parameter int unsigned CLK_HZ = 250_000_000,
    parameter int          REG_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             baud_tick,
    input logic             bit_start,
    input logic             txd,
    input logic             reg_we,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             ir_out,
    input logic             en,
    input logic             tick_act,
    input logic             cyc_act
);
    localparam int LP_CYCLES =
        int'((64'(CLK_HZ) * 64'd16 + 64'd9_999_999) / 64'd10_000_000);
    localparam int HW = $clog2(LP_CYCLES + 2);

    logic [HW-1:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_len <= '0;
        else if (cyc_act) hi_len <= hi_len + 1'b1;
        else              hi_len <= '0;
    end

    // R2: written enable/low-power bits read back on the next cycle
    p_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_rdata[1:0] == $past(reg_wdata[1:0])));

    // R3: NRZ path follows the previous txd
    p_nrz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !en) |-> (ir_out == $past(txd)));

    // R7: a modulated pulse only rises after a qualified zero-bit strobe
    p_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $rose(ir_out)) |-> $past(bit_start && baud_tick && !txd));

    // R7/R9: never two timers running at once
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tick_act, cyc_act}));

    // R6: fixed pulse lasts exactly LP_CYCLES clocks unless cut by disable
    p_lpwidth_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cyc_act) && en) |-> (hi_len == HW'(LP_CYCLES)));
endmodule

bind irsir_mod irsir_mod_chk #(.CLK_HZ(CLK_HZ), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .bit_start (bit_start),
    .txd       (txd),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ir_out    (ir_out),
    .en        (cfg_en),
    .tick_act  (tick_act),
    .cyc_act   (cyc_act)
);

// File: tb/irsir_mod_tb.sv
`timescale 1ns/1ps
module irsir_mod_tb;
    localparam int TDIV  = 34;            // clocks per baud tick
    localparam int W_STD = 3 * TDIV;      // 3/16 pulse in clocks
    localparam int W_LP  = 400;           // ceil(250e6 * 1.6us)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0, bit_start = 1'b0, txd = 1'b1, reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ir_out;

    int total = 0, bad = 0;
    bit finished = 0;

    // monitor state
    bit   mon_on = 0, nrz_on = 0;
    int   run = 0, pulses = 0, bad_w = 0, last_w = 0, exp_w = 0, nrz_bad = 0;
    logic txd_prev = 1'b1;

    always #2 clk = ~clk;

    irsir_mod u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bit_start(bit_start),
        .txd(txd), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ir_out(ir_out)
    );

    always @(posedge clk) txd_prev <= txd;

    always @(negedge clk) begin
        if (mon_on) begin
            if (ir_out === 1'b1) run = run + 1;
            else if (run != 0) begin
                pulses = pulses + 1;
                if (run != exp_w) begin bad_w = bad_w + 1; last_w = run; end
                run = 0;
            end
        end
        if (nrz_on && ir_out !== txd_prev) nrz_bad = nrz_bad + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic tk, input logic bs, input logic d,
                       input logic we, input logic [31:0] wd);
        @(posedge clk); #1;
        baud_tick = tk; bit_start = bs; txd = d; reg_we = we; reg_wdata = wd;
    endtask

    task automatic wr(input logic [31:0] v);
        cyc(1'b0, 1'b0, txd, 1'b1, v);
        cyc(1'b0, 1'b0, txd, 1'b0, '0);
    endtask

    task automatic clr_mon();
        run = 0; pulses = 0; bad_w = 0; last_w = 0; nrz_bad = 0;
    endtask

    task automatic send_bit(input logic b);
        for (int t = 0; t < 16; t++)
            for (int c = 0; c < TDIV; c++)
                cyc(c == 0, (c == 0) && (t == 0), b, 1'b0, '0);
    endtask

    function automatic int zeros_in(input logic [7:0] v);
        return 1 + 8 - $countones(v);
    endfunction

    function automatic int width_for(input int mode);
        return (mode == 2) ? W_LP : W_STD;
    endfunction

    // mode: 0 NRZ, 1 3/16 pulse, 2 fixed low-power pulse
    task automatic frame(input int mode, input logic [7:0] v);
        wr((mode == 0) ? 32'h0 : (mode == 1) ? 32'h1 : 32'h3);
        clr_mon();
        exp_w = width_for(mode);
        mon_on = (mode != 0);
        nrz_on = (mode == 0);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        send_bit(1'b1);
        @(negedge clk);
        mon_on = 0; nrz_on = 0;
        if (mode == 0)
            check(nrz_bad == 0, "R3 nrz mismatches", nrz_bad, 0);
        else begin
            check(pulses == zeros_in(v), (mode == 1) ? "R4/R5 pulse count" : "R6/R5 pulse count",
                  pulses, zeros_in(v));
            check(bad_w == 0, (mode == 1) ? "R4 pulse width" : "R6 pulse width", last_w, exp_w);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(reg_rdata == 32'h0, "R1 reset rdata", int'(reg_rdata), 0);
        check(ir_out == 1'b1, "R1 reset ir_out follows idle txd", int'(ir_out), 1);

        // R2: register mapping and ignored upper bits
        wr(32'hFFFF_FFFE);
        @(negedge clk);
        check(reg_rdata == 32'h2, "R2 readback lp only", int'(reg_rdata), 2);
        wr(32'hFFFF_FFFF);
        @(negedge clk);
        check(reg_rdata == 32'h3, "R2 readback both", int'(reg_rdata), 3);

        // directed all-zero / all-one frames in every mode
        for (int m = 0; m < 3; m++) begin
            frame(m, 8'h00);
            frame(m, 8'hFF);
        end

        // R7: strobe without a tick, strobe during a running pulse
        wr(32'h1);
        clr_mon(); exp_w = W_STD; mon_on = 1;
        for (int c = 0; c < 20; c++) cyc(1'b0, c == 5, 1'b0, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
        @(negedge clk);
        check(pulses == 0 && run == 0, "R7 strobe without tick", pulses + run, 0);
        clr_mon();
        for (int c = 0; c < 5 * TDIV; c++)
            cyc((c % TDIV) == 0, (c == 0) || (c == TDIV), 1'b0, 1'b0, '0);
        @(negedge clk);
        check(pulses == 1 && bad_w == 0, "R7 retrigger ignored", last_w, W_STD);
        mon_on = 0;

        // R9: low-power select flipped during a 3/16 pulse
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
        clr_mon(); exp_w = W_STD; mon_on = 1;
        for (int c = 0; c < 5 * TDIV; c++)
            cyc((c % TDIV) == 0, c == 0, 1'b0, c == 12, 32'h3);
        @(negedge clk);
        check(pulses == 1 && bad_w == 0, "R9 width kept after lp change", last_w, W_STD);
        mon_on = 0;

        // R8: clearing enable in mid-pulse
        wr(32'h3);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
        for (int c = 0; c < 30; c++) cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);
        check(ir_out == 1'b1, "R8 pulse running before disable", int'(ir_out), 1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
        @(negedge clk);
        check(ir_out == 1'b0, "R8 pulse cut, NRZ low", int'(ir_out), 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
        @(negedge clk);
        check(ir_out == 1'b1, "R8 NRZ follows txd", int'(ir_out), 1);

        // random frames
        for (int k = 0; k < 10; k++) begin
            int          m;
            logic [7:0]  v;
            m = int'($urandom % 3);
            v = 8'($urandom);
            frame(m, v);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule